// File: doc/BRIEF.md
# Accelerator Command Queue Host Interface

This block sits between a host processor and a drawing engine. The host sees a small bank of 16-bit registers. It builds each 32-bit engine command from two register writes, upper half first. The write of the lower half completes the word and places it in a deep first-in first-out queue. The engine takes words from the queue through a valid/ready handshake.

The host can read how many words are waiting, so it knows how much room is left before it writes a batch. It can also empty the queue at once. When the engine reports a finished command, a status bit is set. That bit is cleared by writing a one to it. Together with an enable bit, it drives a level interrupt line. A push into a full queue is discarded and leaves a sticky overflow bit in the same status register.

Word assembly is a two-state machine:
- `ASM_EXPECT_HI` (the reset state): the transition LOAD_HI moves to `ASM_EXPECT_LO` on an upper-half write. The loop ORPHAN_LO stays here and discards a lower-half write.
- `ASM_EXPECT_LO`: the loop RELOAD_HI replaces the held upper half. The transition COMPLETE returns to `ASM_EXPECT_HI` on a lower-half write and pushes the word.

Top module: `cmdq_host_if`

## Requirements
- R1: A write to the upper-command register (word offset 0) followed by a write to the lower-command register (offset 1) pushes the word {upper, lower} into the queue.
- R2: A lower-command write with no upper half pending (machine in `ASM_EXPECT_HI`) is discarded and leaves the count unchanged.
- R3: The count register (offset 2) reads the number of queued words, from 0 up to DEPTH (512).
- R4: Words leave on `cmd_data` in push order. `cmd_valid` is high whenever the count is nonzero. One word is removed in each cycle with `cmd_valid` and `cmd_ready` both high.
- R5: A push while DEPTH words are held is discarded and sets sticky status bit 1 (overflow).
- R6: A write to the clear register (offset 3) with bit 0 set empties the queue. The same write with bit 0 clear has no effect.
- R7: A `cmd_done` pulse sets status bit 0 (offset 4). A write to the status register clears exactly the bits written as 1, and a set in the same cycle takes priority over the clear.
- R8: `irq` is high exactly while status bit 0 and the enable bit (offset 5, bit 0) are both 1.
- R9: A push and a pop in the same cycle leave the count unchanged.
- R10: The size register (offset 6) reads DEPTH-1 (511).
- R11: A second upper-command write before the lower write replaces the pending upper half.
- R12: After reset the queue is empty, `cmd_valid`, `irq`, status and enable are 0, and the machine is in `ASM_EXPECT_HI`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 3 | Register word offset |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for `host_addr`, combinational |
| cmd_valid | output | 1 | Queue head is valid |
| cmd_ready | input | 1 | Engine accepts the head word |
| cmd_data | output | 32 | Queue head word |
| cmd_done | input | 1 | Engine reports a completed command |
| irq | output | 1 | Level completion interrupt |

## Verification
The hardest state to reach from the ports is a push and a pop landing in the same cycle. The bench reaches it by raising `cmd_ready` for exactly one cycle on the same clock edge as a lower-command write, and then reading the count. The full-queue boundary is also hard to reach: the bench holds `cmd_ready` low through 512 register-pair pushes and then a 513th, and a scoreboard checks that the overflow word never comes out of the drain.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic {
        ASM_EXPECT_HI = 1'b0,
        ASM_EXPECT_LO = 1'b1
    } asm_state_e;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CMD_HI = 3'd0;
    localparam logic [REG_AW-1:0] A_CMD_LO = 3'd1;
    localparam logic [REG_AW-1:0] A_COUNT  = 3'd2;
    localparam logic [REG_AW-1:0] A_CLEAR  = 3'd3;
    localparam logic [REG_AW-1:0] A_ISTAT  = 3'd4;
    localparam logic [REG_AW-1:0] A_IEN    = 3'd5;
    localparam logic [REG_AW-1:0] A_SIZE   = 3'd6;

endpackage

// File: rtl/cmdq_word_asm.sv
module cmdq_word_asm
    import cmdq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hi,
    input  logic        wr_lo,
    input  logic [15:0] wdata,
    output logic        push_req,
    output logic [31:0] push_word,
    output asm_state_e  state_q
);

    asm_state_e  state_d;
    logic [15:0] hi_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ASM_EXPECT_HI;
        else        state_q <= state_d;
    end

    // pending upper half
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= wdata;
    end

    // transitions: LOAD_HI, ORPHAN_LO, RELOAD_HI, COMPLETE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ASM_EXPECT_HI: if (wr_hi) state_d = ASM_EXPECT_LO;
            ASM_EXPECT_LO: if (wr_lo) state_d = ASM_EXPECT_HI;
            default:       state_d = ASM_EXPECT_HI;
        endcase
    end

    // outputs
    always_comb begin
        push_req  = 1'b0;
        push_word = {hi_q, wdata};
        unique case (state_q)
            ASM_EXPECT_HI: push_req = 1'b0;
            ASM_EXPECT_LO: push_req = wr_lo;
            default:       push_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_req,
    input  logic [W-1:0]                   push_word,
    input  logic                           clr,
    input  logic                           pop_ready,
    output logic                           out_valid,
    output logic [W-1:0]                   out_data,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           push_ok,
    output logic                           pop,
    output logic                           ovf_evt
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full;

    assign full      = (count == CW'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rptr];
    assign push_ok   = push_req && !full;
    assign pop       = out_valid && pop_ready;
    assign ovf_evt   = push_req && full;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)     rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_done,
    input  logic       ovf_evt,
    input  logic       stat_wr,
    input  logic [1:0] stat_wdata,
    input  logic       en_wr,
    input  logic       en_wdata,
    output logic [1:0] stat,
    output logic       irq_en,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat   <= '0;
            irq_en <= 1'b0;
        end else begin
            stat <= (stat & ~(stat_wr ? stat_wdata : 2'b00)) | {ovf_evt, cmd_done};
            if (en_wr) irq_en <= en_wdata;
        end
    end

    assign irq = stat[0] & irq_en;

endmodule

// File: rtl/cmdq_host_if.sv
module cmdq_host_if
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [31:0] cmd_data,
    input  logic        cmd_done,
    output logic        irq
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          wr_hi, wr_lo, clr, stat_wr, en_wr;
    logic          push_req, push_ok, pop, ovf_evt, irq_en;
    logic [31:0]   push_word;
    logic [CW-1:0] fifo_count;
    logic [1:0]    stat;
    asm_state_e    asm_state;

    assign wr_hi   = host_wr && (host_addr == A_CMD_HI);
    assign wr_lo   = host_wr && (host_addr == A_CMD_LO);
    assign clr     = host_wr && (host_addr == A_CLEAR) && host_wdata[0];
    assign stat_wr = host_wr && (host_addr == A_ISTAT);
    assign en_wr   = host_wr && (host_addr == A_IEN);

    cmdq_word_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wdata     (host_wdata),
        .push_req  (push_req),
        .push_word (push_word),
        .state_q   (asm_state)
    );

    cmdq_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_word (push_word),
        .clr       (clr),
        .pop_ready (cmd_ready),
        .out_valid (cmd_valid),
        .out_data  (cmd_data),
        .count     (fifo_count),
        .push_ok   (push_ok),
        .pop       (pop),
        .ovf_evt   (ovf_evt)
    );

    cmdq_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_done   (cmd_done),
        .ovf_evt    (ovf_evt),
        .stat_wr    (stat_wr),
        .stat_wdata (host_wdata[1:0]),
        .en_wr      (en_wr),
        .en_wdata   (host_wdata[0]),
        .stat       (stat),
        .irq_en     (irq_en),
        .irq        (irq)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_COUNT: host_rdata = 16'(fifo_count);
            A_ISTAT: host_rdata = {14'd0, stat};
            A_IEN:   host_rdata = {15'd0, irq_en};
            A_SIZE:  host_rdata = 16'(DEPTH - 1);
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdq_host_chk.sv
module cmdq_host_chk
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       push_ok,
    input logic                       pop,
    input logic                       clr,
    input logic                       cmd_valid,
    input logic                       cmd_done,
    input logic [1:0]                 stat,
    input logic                       irq_en,
    input logic                       irq,
    input asm_state_e                 asm_state,
    input logic                       wr_lo
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R4
    valid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |-> !cmd_valid);

    // R9
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop && !clr) |=> $stable(fifo_count));

    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fifo_count == '0));

    // R7
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> stat[0]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R2
    orphan_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asm_state == ASM_EXPECT_HI && wr_lo) |-> !push_ok);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH) && !pop && !clr) |=> (fifo_count == CW'(DEPTH)));

endmodule

bind cmdq_host_if cmdq_host_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .push_ok    (push_ok),
    .pop        (pop),
    .clr        (clr),
    .cmd_valid  (cmd_valid),
    .cmd_done   (cmd_done),
    .stat       (stat),
    .irq_en     (irq_en),
    .irq        (irq),
    .asm_state  (asm_state),
    .wr_lo      (wr_lo)
);

// File: tb/tb_cmdq_host_if.sv
`timescale 1ns/1ps
module tb_cmdq_host_if;

    localparam int unsigned DEPTH = 512;

    localparam logic [2:0] O_HI = 3'd0, O_LO = 3'd1, O_CNT = 3'd2, O_CLR = 3'd3,
                           O_STAT = 3'd4, O_EN = 3'd5, O_SIZE = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_data;
    logic        cmd_done = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    cmdq_host_if #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_done(cmd_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare every word the engine takes with the scoreboard
    always @(posedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 actual=%h expected=<none>", cmd_data);
            end else begin
                if (cmd_data !== exp_q[0]) begin
                    fails++;
                    $display("FAIL R4 actual=%h expected=%h", cmd_data, exp_q[0]);
                end
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic push_cmd(input logic [31:0] w, input bit accepted);
        wr(O_HI, w[31:16]);
        if (accepted) exp_q.push_back(w);
        wr(O_LO, w[15:0]);
    endtask

    task automatic drain(input int n);
        @(negedge clk);
        cmd_ready = 1'b1;
        repeat (n + 2) @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state, R10 size register
        rd(O_CNT, v);  chk("R12 count", 32'(v), 0);
        chk("R12 valid", 32'(cmd_valid), 0);
        chk("R12 irq", 32'(irq), 0);
        rd(O_STAT, v); chk("R12 status", 32'(v), 0);
        rd(O_EN, v);   chk("R12 enable", 32'(v), 0);
        rd(O_SIZE, v); chk("R10 size", 32'(v), DEPTH - 1);

        // R1 assembly, R3 count, R4 order
        push_cmd(32'hDEAD_BEEF, 1);
        push_cmd(32'h1234_5678, 1);
        push_cmd(32'h0000_FFFF, 1);
        rd(O_CNT, v); chk("R3 count three", 32'(v), 3);
        chk("R4 valid nonempty", 32'(cmd_valid), 1);
        chk("R1 head word", cmd_data, 32'hDEAD_BEEF);
        drain(3);
        rd(O_CNT, v); chk("R4 drained count", 32'(v), 0);
        chk("R4 scoreboard empty", 32'(exp_q.size()), 0);

        // R2 orphan low write is dropped
        wr(O_LO, 16'hAAAA);
        rd(O_CNT, v); chk("R2 orphan low", 32'(v), 0);
        chk("R2 valid stays low", 32'(cmd_valid), 0);

        // R11 second upper write replaces the first
        wr(O_HI, 16'h1111);
        wr(O_HI, 16'h2222);
        exp_q.push_back(32'h2222_3333);
        wr(O_LO, 16'h3333);
        rd(O_CNT, v); chk("R11 count", 32'(v), 1);
        chk("R11 word", cmd_data, 32'h2222_3333);
        drain(1);

        // R9 push and pop in the same cycle
        push_cmd(32'hA000_0001, 1);
        push_cmd(32'hA000_0002, 1);
        wr(O_HI, 16'hB000);
        exp_q.push_back(32'hB000_0003);
        @(negedge clk);
        host_wr = 1'b1; host_addr = O_LO; host_wdata = 16'h0003; cmd_ready = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cmd_ready = 1'b0;
        rd(O_CNT, v); chk("R9 count held", 32'(v), 2);
        chk("R9 new head", cmd_data, 32'hA000_0002);
        drain(2);
        chk("R9 scoreboard empty", 32'(exp_q.size()), 0);

        // R6 clear with bit 0 low ignored, with bit 0 high empties
        push_cmd(32'hC000_0001, 1);
        push_cmd(32'hC000_0002, 1);
        wr(O_CLR, 16'hFFFE);
        rd(O_CNT, v); chk("R6 clear bit0 low", 32'(v), 2);
        wr(O_CLR, 16'h0001);
        rd(O_CNT, v); chk("R6 clear count", 32'(v), 0);
        chk("R6 clear valid", 32'(cmd_valid), 0);
        exp_q.delete();

        // R5 full queue drops a push and sets overflow
        for (int i = 0; i < DEPTH; i++) push_cmd(32'h5000_0000 + 32'(i), 1);
        rd(O_CNT, v); chk("R3 full count", 32'(v), DEPTH);
        rd(O_STAT, v); chk("R5 no overflow yet", 32'(v), 0);
        push_cmd(32'hBAD0_BAD0, 0);
        rd(O_CNT, v); chk("R5 count after drop", 32'(v), DEPTH);
        rd(O_STAT, v); chk("R5 overflow bit", 32'(v), 2);
        drain(DEPTH);
        rd(O_CNT, v); chk("R5 drained", 32'(v), 0);
        chk("R5 scoreboard empty", 32'(exp_q.size()), 0);
        rd(O_STAT, v); chk("R5 overflow sticky", 32'(v), 2);

        // R7 completion status and W1C, R8 interrupt gating
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        rd(O_STAT, v); chk("R7 done set", 32'(v), 3);
        chk("R8 irq masked", 32'(irq), 0);
        wr(O_EN, 16'h0001);
        #1 chk("R8 irq enabled", 32'(irq), 1);
        wr(O_STAT, 16'h0002);
        rd(O_STAT, v); chk("R7 clear only overflow", 32'(v), 1);
        chk("R8 irq still high", 32'(irq), 1);
        // R7 set wins over clear in the same cycle
        @(negedge clk);
        host_wr = 1'b1; host_addr = O_STAT; host_wdata = 16'h0001; cmd_done = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cmd_done = 1'b0;
        rd(O_STAT, v); chk("R7 set priority", 32'(v), 1);
        wr(O_STAT, 16'h0001);
        rd(O_STAT, v); chk("R7 done cleared", 32'(v), 0);
        chk("R8 irq low", 32'(irq), 0);

        ended = 1;
        summary();
    end

endmodule